// File: doc/BRIEF.md
# USB Endpoint Transfer Error Tagger

This block sits beside the data path of one endpoint in a USB device controller. Each completed packet is classified, and the outcome is written into the status byte of the transfer descriptor that is currently active. The block looks at the byte count, the CRC result, the direction and the endpoint type. It raises an overflow when a received packet is longer than the endpoint's maximum packet size or longer than the buffer space left. An overflow halts the endpoint, and the rest of the descriptor chain is skipped. On an isochronous endpoint a received CRC error is tagged in the status and never retried. On any other endpoint type a CRC error becomes a retry request, and no error bits are written.

For isochronous endpoints the block also counts the packets that complete in each microframe. At the next microframe start it compares that count with the per-microframe multiplier. If too few packets arrived, it tags a fulfillment error and idles the pipe for one whole microframe. The pipe primes again at the microframe start that follows.

Top module: `usb_ep_err_tagger`

## Requirements
- R1: A received packet (`pkt_rx`=1) is an overflow when `pkt_bytes` is greater than `max_pkt` or greater than `buf_rem`. A count equal to either limit is not an overflow. The endpoint type does not matter.
- R2: An overflow writes status 0x20 (bit 5 data-buffer error set, bit 3 transaction error clear) and sets `ep_halt` and `skip_chain`.
- R3: `ep_halt` stays set until `halt_clr` is pulsed. While it is set, completed packets cause no status write and no retry.
- R4: A received isochronous packet with `pkt_crc_ok`=0 writes status 0x08 (bit 3 only) and pulses `data_bad`. It never raises `retry_req`.
- R5: A received non-isochronous packet with `pkt_crc_ok`=0 pulses `retry_req` and makes no status write.
- R6: A packet that completes without error writes status 0x00. The CRC input is ignored for transmit packets (`pkt_rx`=0).
- R7: Every status write appears as a one-cycle `sts_we` pulse, together with `dtd_status`, in the cycle after the `pkt_done` or `uframe_sof` that caused it.
- R8: At `uframe_sof`, an isochronous endpoint whose completed-packet count in the microframe just ended is below `mult` gets a status write of 0x08 and enters a dead microframe (`dead_uframe`=1). The first `uframe_sof` after reset only starts counting. Non-isochronous endpoints are never flagged.
- R9: During a dead microframe, packets cause no status write and are not counted. The next `uframe_sof` ends the dead microframe without a shortfall check.
- R10: Packets in both directions count toward fulfillment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep_iso | input | 1 | 1 = isochronous endpoint |
| max_pkt | input | MPS_W | Max packet size in bytes |
| buf_rem | input | LEN_W | Bytes left in the descriptor buffer |
| mult | input | MULT_W | Packets expected per microframe |
| pkt_done | input | 1 | Packet completion pulse |
| pkt_rx | input | 1 | 1 = receive, 0 = transmit |
| pkt_bytes | input | LEN_W | Bytes in the completed packet |
| pkt_crc_ok | input | 1 | CRC of the received packet was good |
| uframe_sof | input | 1 | Microframe start pulse |
| halt_clr | input | 1 | Software clear of the halt flag |
| sts_we | output | 1 | Descriptor status write strobe |
| dtd_status | output | 8 | Status byte to write |
| ep_halt | output | 1 | Endpoint halted |
| skip_chain | output | 1 | Abandon the remaining descriptors |
| retry_req | output | 1 | Retry request for a non-isochronous error |
| data_bad | output | 1 | Received isochronous data is unreliable |
| dead_uframe | output | 1 | Pipe idle for this microframe |

## Verification
The dead microframe is the hardest state to reach. The stimulus first needs one priming microframe start. It then needs a microframe with fewer isochronous packets than the multiplier, closed by a second start. At that point the bench sends a packet inside the dead microframe and checks that it is ignored. After that it checks that the following start re-primes the pipe without flagging a second shortfall. A microframe that meets the multiplier with mixed directions, and a microframe with zero packets on a bulk endpoint, show that only a real isochronous shortfall is flagged.

// File: rtl/usb_err_pkg.sv
// Shared encodings for the endpoint error tagger.
// Assumes the descriptor status byte uses bit 5 for buffer errors and
// bit 3 for transaction errors.
package usb_err_pkg;
    localparam int BUF_ERR_BIT = 5;
    localparam int TXN_ERR_BIT = 3;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_TXN  = 2'd1,
        ERR_BUF  = 2'd2
    } err_e;

    // Map an error class onto the descriptor status byte.
    function automatic logic [7:0] status_of(err_e e);
        logic [7:0] s;
        s = 8'h00;
        if (e == ERR_BUF) s[BUF_ERR_BIT] = 1'b1;
        if (e == ERR_TXN) s[TXN_ERR_BIT] = 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/ep_pkt_classify.sv
// Combinational packet classifier.
// Decides for one completed packet whether it overflowed, had a CRC error,
// needs a retry, and whether a status write follows.
// Assumes MPS_W <= LEN_W. `blocked` gates out packets while the endpoint is
// halted or the pipe is dead.
module ep_pkt_classify #(
    parameter int MPS_W = 11,
    parameter int LEN_W = 16
) (
    input  logic             pkt_done,
    input  logic             pkt_rx,
    input  logic             pkt_crc_ok,
    input  logic             ep_iso,
    input  logic [LEN_W-1:0] pkt_bytes,
    input  logic [MPS_W-1:0] max_pkt,
    input  logic [LEN_W-1:0] buf_rem,
    input  logic             blocked,
    output logic             accept,
    output logic             ovf,
    output logic             iso_crc,
    output logic             retry,
    output logic             wr
);
    localparam int PAD_W = LEN_W - MPS_W;

    logic [LEN_W-1:0] mps_ext;
    logic             bad_crc;

    // Classify the packet against the size limits and the CRC result.
    always_comb begin
        mps_ext = {{PAD_W{1'b0}}, max_pkt};
        accept  = pkt_done && !blocked;
        ovf     = accept && pkt_rx && ((pkt_bytes > mps_ext) || (pkt_bytes > buf_rem));
        bad_crc = accept && pkt_rx && !pkt_crc_ok && !ovf;
        iso_crc = bad_crc && ep_iso;
        retry   = bad_crc && !ep_iso;
        wr      = accept && !retry;
    end
endmodule

// File: rtl/ep_uframe_track.sv
// Microframe fulfillment tracker.
// Counts accepted packets in each microframe and checks the count against
// the multiplier at the next start pulse. On a shortfall the pipe stays dead
// for one microframe. Assumes one start pulse per microframe. The first
// pulse after reset only primes the tracker.
module ep_uframe_track #(
    parameter int MULT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uframe_sof,
    input  logic              ep_iso,
    input  logic [MULT_W-1:0] mult,
    input  logic              pkt_in,
    output logic              short_now,
    output logic              dead
);
    localparam int CNT_W = MULT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;
    logic             dead_q;
    logic             take;

    // Shortfall decision and packet gating for the current cycle.
    always_comb begin
        take      = pkt_in && !dead_q;
        short_now = uframe_sof && ep_iso && primed_q && !dead_q &&
                    (cnt_q < {1'b0, mult});
    end

    // Per-microframe count, priming and dead-frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            primed_q <= 1'b0;
            dead_q   <= 1'b0;
        end else if (uframe_sof) begin
            primed_q <= 1'b1;
            dead_q   <= short_now;
            cnt_q    <= (take && !short_now) ? CNT_W'(1) : '0;
        end else if (take && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dead = dead_q;

    // R9
    dead_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dead_q) |-> $past(uframe_sof));

    // R9
    dead_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_q && !uframe_sof) |=> dead_q);
endmodule

// File: rtl/usb_ep_err_tagger.sv
// Endpoint transfer error tagger (top).
// Turns classifier and tracker results into one registered descriptor
// status write per event, and keeps the halt/skip flag.
// Assumes pkt_done, uframe_sof and halt_clr are single-cycle pulses.
module usb_ep_err_tagger #(
    parameter int MPS_W  = 11,
    parameter int LEN_W  = 16,
    parameter int MULT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ep_iso,
    input  logic [MPS_W-1:0]  max_pkt,
    input  logic [LEN_W-1:0]  buf_rem,
    input  logic [MULT_W-1:0] mult,
    input  logic              pkt_done,
    input  logic              pkt_rx,
    input  logic [LEN_W-1:0]  pkt_bytes,
    input  logic              pkt_crc_ok,
    input  logic              uframe_sof,
    input  logic              halt_clr,
    output logic              sts_we,
    output logic [7:0]        dtd_status,
    output logic              ep_halt,
    output logic              skip_chain,
    output logic              retry_req,
    output logic              data_bad,
    output logic              dead_uframe
);
    import usb_err_pkg::*;

    logic       halt_q;
    logic       dead;
    logic       accept, ovf, iso_crc, retry, wr, short_now;
    logic       we_q, retry_q, bad_q;
    logic [7:0] sts_q;
    err_e       code;

    ep_pkt_classify #(.MPS_W(MPS_W), .LEN_W(LEN_W)) u_cls (
        .pkt_done(pkt_done), .pkt_rx(pkt_rx), .pkt_crc_ok(pkt_crc_ok),
        .ep_iso(ep_iso), .pkt_bytes(pkt_bytes), .max_pkt(max_pkt),
        .buf_rem(buf_rem), .blocked(halt_q || dead), .accept(accept),
        .ovf(ovf), .iso_crc(iso_crc), .retry(retry), .wr(wr)
    );

    ep_uframe_track #(.MULT_W(MULT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .uframe_sof(uframe_sof), .ep_iso(ep_iso),
        .mult(mult), .pkt_in(pkt_done && !halt_q), .short_now(short_now),
        .dead(dead)
    );

    // Error class priority: overflow, then shortfall, then isochronous CRC.
    always_comb begin
        if (ovf)                       code = ERR_BUF;
        else if (short_now || iso_crc) code = ERR_TXN;
        else                           code = ERR_NONE;
    end

    // Registered status write, retry and data-quality pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            sts_q   <= 8'h00;
            retry_q <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            we_q    <= wr || short_now;
            sts_q   <= (wr || short_now) ? status_of(code) : 8'h00;
            retry_q <= retry;
            bad_q   <= iso_crc;
        end
    end

    // Halt flag: set by overflow, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        halt_q <= 1'b0;
        else if (ovf)      halt_q <= 1'b1;
        else if (halt_clr) halt_q <= 1'b0;
    end

    assign sts_we      = we_q;
    assign dtd_status  = sts_q;
    assign ep_halt     = halt_q;
    assign skip_chain  = halt_q;
    assign retry_req   = retry_q;
    assign data_bad    = bad_q;
    assign dead_uframe = dead;

    // R2
    ovf_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && dtd_status[BUF_ERR_BIT]) |-> ep_halt);

    // R2
    code_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_we |-> !(dtd_status[BUF_ERR_BIT] && dtd_status[TXN_ERR_BIT]));

    // R5
    retry_no_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> !sts_we);

    // R4
    iso_no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && ep_iso) |=> !retry_req);

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_halt && !halt_clr) |=> ep_halt);

    // R3
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_halt && pkt_done && !uframe_sof) |=> (!sts_we && !retry_req));
endmodule

// File: tb/sim_usb_ep_err_tagger.sv
module sim_usb_ep_err_tagger;
    localparam int CLK_PERIOD = 10;
    localparam int MPS_W = 11, LEN_W = 16, MULT_W = 2;

    typedef struct {
        logic       we;
        logic [7:0] sts;
        logic       halt, retry, bad, dead;
        string      req;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ep_iso = 0, pkt_done = 0, pkt_rx = 0, pkt_crc_ok = 1;
    logic uframe_sof = 0, halt_clr = 0;
    logic [MPS_W-1:0]  max_pkt = 11'd64;
    logic [LEN_W-1:0]  buf_rem = 16'd512, pkt_bytes = '0;
    logic [MULT_W-1:0] mult = 2'd2;
    logic sts_we, ep_halt, skip_chain, retry_req, data_bad, dead_uframe;
    logic [7:0] dtd_status;

    int errors = 0, checks = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_ep_err_tagger #(.MPS_W(MPS_W), .LEN_W(LEN_W), .MULT_W(MULT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ep_iso(ep_iso), .max_pkt(max_pkt),
        .buf_rem(buf_rem), .mult(mult), .pkt_done(pkt_done), .pkt_rx(pkt_rx),
        .pkt_bytes(pkt_bytes), .pkt_crc_ok(pkt_crc_ok), .uframe_sof(uframe_sof),
        .halt_clr(halt_clr), .sts_we(sts_we), .dtd_status(dtd_status),
        .ep_halt(ep_halt), .skip_chain(skip_chain), .retry_req(retry_req),
        .data_bad(data_bad), .dead_uframe(dead_uframe)
    );

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected outcome.
    task automatic step(input logic iso, rx, done, crc, sof, clr,
                        input int bytes, input logic e_we, input logic [7:0] e_sts,
                        input logic e_halt, e_retry, e_bad, e_dead, input string req);
        exp_t e;
        @(negedge clk);
        ep_iso = iso; pkt_rx = rx; pkt_done = done; pkt_crc_ok = crc;
        uframe_sof = sof; halt_clr = clr; pkt_bytes = LEN_W'(bytes);
        e.we = e_we; e.sts = e_sts; e.halt = e_halt; e.retry = e_retry;
        e.bad = e_bad; e.dead = e_dead; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input logic iso, e_halt, e_dead, input string req);
        step(iso, 0, 0, 1, 0, 0, 0, 0, 8'h00, e_halt, 0, 0, e_dead, req);
    endtask

    // Monitor: compare each registered result just after its clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.req, "sts_we", sts_we, e.we);
                if (e.we) cmp(e.req, "dtd_status", dtd_status, e.sts);
                cmp(e.req, "ep_halt", ep_halt, e.halt);
                cmp(e.req, "skip_chain", skip_chain, e.halt);
                cmp(e.req, "retry_req", retry_req, e.retry);
                cmp(e.req, "data_bad", data_bad, e.bad);
                cmp(e.req, "dead_uframe", dead_uframe, e.dead);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        cmp("R7", "reset sts_we", sts_we, 0);
        cmp("R3", "reset halt", ep_halt, 0);
        cmp("R9", "reset dead", dead_uframe, 0);
        // R6 clean packet, byte count equal to max packet size (R1 boundary)
        step(0, 1, 1, 1, 0, 0, 64, 1, 8'h00, 0, 0, 0, 0, "R1");
        idle(0, 0, 0, "R7");
        // R1/R2 overflow against max packet size
        step(0, 1, 1, 1, 0, 0, 65, 1, 8'h20, 1, 0, 0, 0, "R2");
        // R3 halted: a clean packet and a CRC error are both ignored
        step(0, 1, 1, 1, 0, 0, 10, 0, 8'h00, 1, 0, 0, 0, "R3");
        step(0, 1, 1, 0, 0, 0, 10, 0, 8'h00, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 1, 0, 0, 8'h00, 0, 0, 0, 0, "R3");
        // R1 overflow against remaining buffer length
        buf_rem = 16'd32;
        step(1, 1, 1, 1, 0, 0, 40, 1, 8'h20, 1, 0, 0, 0, "R1");
        step(0, 0, 0, 1, 0, 1, 0, 0, 8'h00, 0, 0, 0, 0, "R3");
        step(0, 1, 1, 1, 0, 0, 32, 1, 8'h00, 0, 0, 0, 0, "R1");
        buf_rem = 16'd512;
        // R5 non-iso CRC error retried
        step(0, 1, 1, 0, 0, 0, 20, 0, 8'h00, 0, 1, 0, 0, "R5");
        // R4 iso CRC error tagged
        step(1, 1, 1, 0, 0, 0, 20, 1, 8'h08, 0, 0, 1, 0, "R4");
        // R6 transmit ignores CRC input
        step(1, 0, 1, 0, 0, 0, 20, 1, 8'h00, 0, 0, 0, 0, "R6");
        // R8 first start only primes even with a low count
        step(1, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, "R8");
        // R10 rx + tx fulfil mult=2
        step(1, 1, 1, 1, 0, 0, 8, 1, 8'h00, 0, 0, 0, 0, "R10");
        step(1, 0, 1, 1, 0, 0, 8, 1, 8'h00, 0, 0, 0, 0, "R10");
        step(1, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, "R10");
        // R8 shortfall: one packet only
        step(1, 1, 1, 1, 0, 0, 8, 1, 8'h00, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 1, 1, 0, 0, 1, 8'h08, 0, 0, 0, 1, "R8");
        // R9 packet in dead microframe ignored
        idle(1, 0, 1, "R9");
        step(1, 1, 1, 1, 0, 0, 8, 0, 8'h00, 0, 0, 0, 1, "R9");
        // R9 next start re-primes with no check
        step(1, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, "R9");
        step(1, 1, 1, 1, 0, 0, 8, 1, 8'h00, 0, 0, 0, 0, "R9");
        step(1, 1, 1, 1, 0, 0, 8, 1, 8'h00, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, "R9");
        // R8 non-iso endpoint with zero packets is never flagged
        step(0, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, "R8");
        idle(0, 0, 0, "R8");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule